// File: doc/BRIEF.md
# Fan Tachometer Speed Monitor

This block measures how fast a fan turns by timing its tachometer output. A fan gives two tach pulses for each revolution. The block divides the system clock down to a 20 kHz time base, divides that again by a selectable factor of 1, 2, 4 or 8, and counts the resulting ticks over one full revolution. A slow fan therefore gives a large count. For example, a fan at 8000 RPM with a factor of 1 gives a count of 150. The count is 1,200,000 / (RPM × factor).

Each finished measurement is latched into a speed-count register and marked by a one-cycle valid strobe. It is then compared with a host-written alarm threshold. If interrupt generation is on and the count is at or above the threshold, a sticky interrupt flag is raised. The flag stays set until the host pulses a clear strobe.

The tach input is synchronised and debounced before any edge is used. The counter saturates instead of wrapping. A timeout reports the full-scale value when a fan stops partway through a revolution.

Top module: `fan_tach_monitor`

## Requirements
- R1: After reset, the control readback, the threshold readback, the speed count and the interrupt output are all 0, and no valid strobe is produced.
- R2: The control register byte holds the run enable in bit 7, the interrupt enable in bit 6 and the factor select in bits 1:0. Bits 5:2 always read 0 whatever is written, so writing FFh reads back C3h. The threshold register reads back the last value written.
- R3: While enabled, a measurement window opens on a filtered rising tach edge and closes on the second filtered rising edge after it. The closing edge also opens the next window. With T system clocks between the opening and closing edges, the latched count is floor((T-1)/(CLK_PER_TICK × factor)), and result_valid pulses high for one cycle with the new count.
- R4: The factor select encodes 00 = 1, 01 = 2, 10 = 4 and 11 = 8. The selected factor scales the tick period in the R3 formula.
- R5: The count saturates at 255 (FFh). A window longer than 255 ticks latches 255.
- R6: If, inside an open window, TIMEOUT_TICKS divided ticks pass with no rising edge, 255 is latched with a valid strobe. The block then waits for a new opening edge.
- R7: A tach level change that lasts fewer than DEB_LEN system clocks is ignored and does not end or split a window.
- R8: When a count is latched with interrupt enable set and the count is at or above the threshold, irq goes high on the next cycle. A count below the threshold, or a count latched with interrupt enable clear, leaves irq low.
- R9: Once set, irq stays high until a one-cycle irq_clear pulse, and after that pulse it reads 0.
- R10: With the run enable clear, tach activity produces no valid strobe and leaves the speed count unchanged, whatever the other control bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tach_in | input | 1 | Asynchronous fan tachometer input |
| ctrl_wr | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 8 | Control write data (enable, interrupt enable, factor select) |
| ctrl_rdata | output | 8 | Control register readback |
| thresh_wr | input | 1 | Write strobe for the alarm threshold |
| thresh_wdata | input | 8 | Threshold write data |
| thresh_rdata | output | 8 | Threshold readback |
| irq_clear | input | 1 | One-cycle strobe that clears the interrupt flag |
| count_rdata | output | 8 | Last latched speed count |
| result_valid | output | 1 | One-cycle strobe when a new count is latched |
| irq | output | 1 | Sticky interrupt request |

## Verification
The embedded properties assume the following about the block's inputs:
- Reset is held for a few clocks before any checking starts.
- DEB_LEN is at least 2 and CLK_PER_TICK is at least 2.
- The host does not pulse irq_clear in the same cycle that a count is latched.

The stimulus keeps within these limits. It changes the tach level only at falling clock edges, keeps every real pulse level far longer than the debounce length, and issues clear strobes only after results have settled. Tach periods are chosen half a tick away from a tick boundary, so every expected count is exact. Between patterns the monitor is disabled so that each pattern starts from the waiting state.

// File: rtl/fan_tach_pkg.sv
// Shared types and helpers for the fan tachometer monitor.
// Assumes an 8-bit speed count and a 2-bit factor select.
package fan_tach_pkg;
    localparam int CNT_W = 8;

    typedef logic [1:0] div_sel_t;

    typedef enum logic {
        MON_IDLE = 1'b0,
        MON_WIN  = 1'b1
    } mon_state_t;

    // Returns (factor - 1) for select codes 00=1, 01=2, 10=4, 11=8.
    function automatic logic [2:0] div_last(input div_sel_t sel);
        case (sel)
            2'b00:   div_last = 3'd0;
            2'b01:   div_last = 3'd1;
            2'b10:   div_last = 3'd3;
            default: div_last = 3'd7;
        endcase
    endfunction
endpackage

// File: rtl/tach_filter.sv
// Synchronises the asynchronous tach input with two flops. It accepts a new
// level only after the synchronised input has differed from the current level
// for DEB_LEN consecutive clocks. It emits a one-cycle pulse on each accepted
// rising edge.
// Assumes DEB_LEN >= 2.
module tach_filter #(
    parameter int DEB_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tach_in,
    output logic rise
);
    localparam int DW = $clog2(DEB_LEN + 1);

    logic          sync1, sync2;
    logic          filt, filt_d;
    logic [DW-1:0] stab_cnt;

    // Synchroniser, stability counter and filtered level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1    <= 1'b0;
            sync2    <= 1'b0;
            filt     <= 1'b0;
            filt_d   <= 1'b0;
            stab_cnt <= '0;
        end else begin
            sync1  <= tach_in;
            sync2  <= sync1;
            filt_d <= filt;
            if (sync2 != filt) begin
                if (stab_cnt == DW'(DEB_LEN - 1)) begin
                    filt     <= sync2;
                    stab_cnt <= '0;
                end else begin
                    stab_cnt <= stab_cnt + 1'b1;
                end
            end else begin
                stab_cnt <= '0;
            end
        end
    end

    assign rise = filt & ~filt_d;

    // R7: an accepted level must have been present for at least two clocks.
    assert_filter_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (filt != $past(filt)) |-> ($past(sync2) == filt && $past(sync2, 2) == filt));
endmodule

// File: rtl/tick_gen.sv
// Divides the system clock by CLK_PER_TICK to make the 20 kHz time base. It
// then divides that by the selected factor to make the counting tick. Both
// stages restart when a measurement window opens, so the tick phase is fixed
// relative to the opening edge.
// Assumes CLK_PER_TICK >= 2.
module tick_gen
    import fan_tach_pkg::*;
#(
    parameter int CLK_PER_TICK = 1000
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     restart,
    input  div_sel_t sel,
    output logic     dtick
);
    localparam int PW = $clog2(CLK_PER_TICK);

    logic [PW-1:0] pre_cnt;
    logic [2:0]    div_cnt;
    logic          base_tick;
    logic          div_hit;

    assign base_tick = (pre_cnt == PW'(CLK_PER_TICK - 1));
    assign div_hit   = (div_cnt >= div_last(sel));
    assign dtick     = en && !restart && base_tick && div_hit;

    // Prescaler and factor divider, both cleared on restart or when off.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || restart) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (base_tick) begin
            pre_cnt <= '0;
            div_cnt <= div_hit ? 3'd0 : div_cnt + 3'd1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    // R4: counting ticks are never back to back.
    assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dtick |=> !dtick);
endmodule

// File: rtl/period_counter.sv
// Counts divided ticks over a window from one rising tach edge to the second
// rising edge after it. It latches the count at the window end, saturating at
// 255, and latches 255 when no edge arrives within TIMEOUT_TICKS ticks.
// Assumes rise and dtick come from tach_filter and tick_gen.
module period_counter
    import fan_tach_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rise,
    input  logic             dtick,
    output logic             start,
    output logic [CNT_W-1:0] result,
    output logic             done
);
    localparam int TW = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

    mon_state_t       state;
    logic             edge_seen;
    logic [CNT_W-1:0] cnt;
    logic [TW-1:0]    to_cnt;

    assign start = en && rise && (state == MON_IDLE || edge_seen);

    // Window state machine, saturating count, timeout and result latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= MON_IDLE;
            edge_seen <= 1'b0;
            cnt       <= '0;
            to_cnt    <= '0;
            result    <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!en) begin
                state <= MON_IDLE;
            end else if (start) begin
                if (state == MON_WIN) begin
                    result <= cnt;
                    done   <= 1'b1;
                end
                state     <= MON_WIN;
                edge_seen <= 1'b0;
                cnt       <= '0;
                to_cnt    <= '0;
            end else if (state == MON_WIN) begin
                if (dtick && cnt != FULL) begin
                    cnt <= cnt + 1'b1;
                end
                if (rise) begin
                    edge_seen <= 1'b1;
                    to_cnt    <= '0;
                end else if (dtick) begin
                    if (to_cnt == TW'(TIMEOUT_TICKS - 1)) begin
                        result <= FULL;
                        done   <= 1'b1;
                        state  <= MON_IDLE;
                    end else begin
                        to_cnt <= to_cnt + 1'b1;
                    end
                end
            end
        end
    end

    // R5: a full count never wraps back.
    assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == FULL && !start) |=> (cnt == FULL));
    // R6: an expired timeout reports full scale.
    assert_timeout_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state == MON_WIN && !rise && dtick && to_cnt == TW'(TIMEOUT_TICKS - 1))
        |=> (done && result == FULL));
    // R10: no result while disabled.
    assert_quiet_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !done);
endmodule

// File: rtl/fan_tach_monitor.sv
// Top of the fan tachometer monitor. It holds the control and threshold
// registers and the sticky interrupt flag, and connects the input filter,
// the tick generator and the period counter.
// Assumes irq_clear is not pulsed in the cycle a result is latched.
module fan_tach_monitor
    import fan_tach_pkg::*;
#(
    parameter int CLK_PER_TICK  = 1000,
    parameter int DEB_LEN       = 16,
    parameter int TIMEOUT_TICKS = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tach_in,
    input  logic             ctrl_wr,
    input  logic [7:0]       ctrl_wdata,
    output logic [7:0]       ctrl_rdata,
    input  logic             thresh_wr,
    input  logic [CNT_W-1:0] thresh_wdata,
    output logic [CNT_W-1:0] thresh_rdata,
    input  logic             irq_clear,
    output logic [CNT_W-1:0] count_rdata,
    output logic             result_valid,
    output logic             irq
);
    logic             run_en, irq_en;
    div_sel_t         div_sel;
    logic [CNT_W-1:0] thresh_q;
    logic             irq_q;
    logic             rise, dtick, start, done;
    logic [CNT_W-1:0] result;
    logic             unused_rsvd;

    assign unused_rsvd = ^ctrl_wdata[5:2];

    // Control register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en  <= 1'b0;
            irq_en  <= 1'b0;
            div_sel <= 2'b00;
        end else if (ctrl_wr) begin
            run_en  <= ctrl_wdata[7];
            irq_en  <= ctrl_wdata[6];
            div_sel <= ctrl_wdata[1:0];
        end
    end

    // Threshold register write.
    always_ff @(posedge clk) begin
        if (!rst_n) thresh_q <= '0;
        else if (thresh_wr) thresh_q <= thresh_wdata;
    end

    // Sticky interrupt flag: set on an alarming result, cleared by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else if (done && irq_en && result >= thresh_q) irq_q <= 1'b1;
        else if (irq_clear) irq_q <= 1'b0;
    end

    tach_filter #(.DEB_LEN(DEB_LEN)) i_filter (
        .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .rise(rise)
    );

    tick_gen #(.CLK_PER_TICK(CLK_PER_TICK)) i_ticks (
        .clk(clk), .rst_n(rst_n), .en(run_en), .restart(start),
        .sel(div_sel), .dtick(dtick)
    );

    period_counter #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) i_period (
        .clk(clk), .rst_n(rst_n), .en(run_en), .rise(rise), .dtick(dtick),
        .start(start), .result(result), .done(done)
    );

    assign ctrl_rdata   = {run_en, irq_en, 4'b0000, div_sel};
    assign thresh_rdata = thresh_q;
    assign count_rdata  = result;
    assign result_valid = done;
    assign irq          = irq_q;

    // R8: an alarming result raises the flag on the next cycle.
    assert_irq_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && irq_en && result >= thresh_q) |=> irq_q);
    // R8: the flag only rises on an enabled result.
    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_q && !(done && irq_en)) |=> !irq_q);
    // R9: the flag holds until cleared.
    assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !irq_clear) |=> irq_q);
    // R9: a clear with no new result drops the flag.
    assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clear && !done) |=> !irq_q);
endmodule

// File: tb/test_fan_tach_monitor.sv
module test_fan_tach_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int P     = 10;
    localparam int DEB   = 4;
    localparam int TOUT  = 300;
    localparam int HIGHT = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tach_in = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic [7:0] ctrl_rdata;
    logic       thresh_wr = 1'b0;
    logic [7:0] thresh_wdata = '0;
    logic [7:0] thresh_rdata;
    logic       irq_clear = 1'b0;
    logic [7:0] count_rdata;
    logic       result_valid;
    logic       irq;

    int  total = 0;
    int  bad = 0;
    int  n_results = 0;
    int  exp_q[$];
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fan_tach_monitor #(.CLK_PER_TICK(P), .DEB_LEN(DEB), .TIMEOUT_TICKS(TOUT)) i_fan_tach_monitor (
        .clk(clk), .rst_n(rst_n), .tach_in(tach_in),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
        .thresh_wr(thresh_wr), .thresh_wdata(thresh_wdata), .thresh_rdata(thresh_rdata),
        .irq_clear(irq_clear), .count_rdata(count_rdata),
        .result_valid(result_valid), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor: pop the expected count on every result strobe.
    always @(negedge clk) begin
        if (rst_n && result_valid) begin
            n_results++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected result", count_rdata, -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(count_rdata == e[7:0], "R3 latched count", count_rdata, e);
            end
        end
    end

    task automatic tclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        ctrl_wdata = v; ctrl_wr = 1'b1; tclk(1); ctrl_wr = 1'b0;
    endtask

    task automatic wr_thresh(input logic [7:0] v);
        thresh_wdata = v; thresh_wr = 1'b1; tclk(1); thresh_wr = 1'b0;
    endtask

    // One tach period: a high pulse then a low level, with an optional short glitch.
    task automatic tach_period(input int period, input bit glitch);
        tach_in = 1'b1; tclk(HIGHT); tach_in = 1'b0;
        if (glitch) begin
            tclk(100); tach_in = 1'b1; tclk(2); tach_in = 1'b0; tclk(period - HIGHT - 102);
        end else begin
            tclk(period - HIGHT);
        end
    endtask

    task automatic wait_empty(input string req);
        int n = 0;
        while (exp_q.size() != 0 && n < 8000) begin tclk(1); n++; end
        if (exp_q.size() != 0) begin
            check(1'b0, req, exp_q.size(), 0);
            exp_q.delete();
        end
        tclk(2);
    endtask

    // Driver: run nwin windows of count k at factor code dc; push expected items.
    task automatic run_window(input logic [1:0] dc, input int k, input int nwin,
                              input logic ien, input bit glitch, input string req);
        int d, t, p1, p2;
        d  = 1 << dc;
        t  = k * P * d + (P * d) / 2;
        p1 = t / 2;
        p2 = t - p1;
        for (int i = 0; i < nwin; i++) exp_q.push_back(k > 255 ? 255 : k);
        wr_ctrl({1'b1, ien, 4'b0000, dc});
        tclk(5);
        for (int i = 0; i < 2 * nwin; i++)
            tach_period((i % 2 == 0) ? p1 : p2, glitch && i == 0);
        tach_in = 1'b1; tclk(HIGHT); tach_in = 1'b0;
        wait_empty(req);
        wr_ctrl({1'b0, ien, 4'b0000, dc});
        tclk(30);
    endtask

    task automatic pulse_clear;
        irq_clear = 1'b1; tclk(1); irq_clear = 1'b0; tclk(1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int nr;
        logic [7:0] held;
        tclk(6);
        rst_n = 1'b1;
        tclk(2);
        // R1 reset state
        check(ctrl_rdata == 8'h00, "R1 ctrl reset", ctrl_rdata, 0);
        check(thresh_rdata == 8'h00, "R1 thresh reset", thresh_rdata, 0);
        check(count_rdata == 8'h00, "R1 count reset", count_rdata, 0);
        check(irq == 1'b0, "R1 irq reset", irq, 0);
        check(result_valid == 1'b0, "R1 no strobe", result_valid, 0);

        // R2 register readback and reserved bits
        wr_ctrl(8'hFF); tclk(1);
        check(ctrl_rdata == 8'hC3, "R2 ctrl reserved bits", ctrl_rdata, 8'hC3);
        wr_ctrl(8'h00); tclk(1);
        check(ctrl_rdata == 8'h00, "R2 ctrl cleared", ctrl_rdata, 0);
        wr_thresh(8'hA5); tclk(1);
        check(thresh_rdata == 8'hA5, "R2 thresh readback", thresh_rdata, 8'hA5);
        wr_thresh(8'd200);

        // R3 basic counts, factor 1, including back-to-back windows
        run_window(2'b00, 150, 1, 1'b0, 1'b0, "R3 count 150 not seen");
        run_window(2'b00, 37, 1, 1'b0, 1'b0, "R3 count 37 not seen");
        run_window(2'b00, 90, 3, 1'b0, 1'b0, "R3 continuous windows not seen");

        // R4 factor encodings
        run_window(2'b01, 100, 1, 1'b0, 1'b0, "R4 factor 2 not seen");
        run_window(2'b10, 60, 1, 1'b0, 1'b0, "R4 factor 4 not seen");
        run_window(2'b11, 40, 1, 1'b0, 1'b0, "R4 factor 8 not seen");

        // R5 saturation
        run_window(2'b00, 280, 1, 1'b0, 1'b0, "R5 saturated count not seen");

        // R6 timeout after a single opening edge
        run_window(2'b00, 50, 1, 1'b0, 1'b0, "R6 setup count not seen");
        exp_q.push_back(255);
        wr_ctrl(8'h80); tclk(5);
        tach_in = 1'b1; tclk(HIGHT); tach_in = 1'b0;
        wait_empty("R6 timeout result not seen");
        check(count_rdata == 8'hFF, "R6 timeout count", count_rdata, 255);
        wr_ctrl(8'h00); tclk(30);

        // R7 short glitch ignored
        run_window(2'b00, 120, 1, 1'b0, 1'b1, "R7 glitch window not seen");

        // R8 / R9 interrupt behaviour
        wr_thresh(8'd100);
        run_window(2'b00, 150, 1, 1'b1, 1'b0, "R8 alarm window not seen");
        check(irq == 1'b1, "R8 irq above threshold", irq, 1);
        tclk(20);
        check(irq == 1'b1, "R9 irq sticky", irq, 1);
        pulse_clear;
        check(irq == 1'b0, "R9 irq cleared", irq, 0);
        run_window(2'b00, 100, 1, 1'b1, 1'b0, "R8 equal window not seen");
        check(irq == 1'b1, "R8 irq at threshold", irq, 1);
        pulse_clear;
        check(irq == 1'b0, "R9 irq cleared again", irq, 0);
        run_window(2'b00, 99, 1, 1'b1, 1'b0, "R8 below window not seen");
        check(irq == 1'b0, "R8 irq below threshold", irq, 0);
        run_window(2'b00, 150, 1, 1'b0, 1'b0, "R8 masked window not seen");
        check(irq == 1'b0, "R8 irq with enable clear", irq, 0);

        // R10 disabled monitor ignores tach
        nr = n_results;
        held = count_rdata;
        wr_ctrl(8'h43); tclk(5);
        for (int i = 0; i < 4; i++) tach_period(800, 1'b0);
        tclk(50);
        check(n_results == nr, "R10 results while off", n_results, nr);
        check(count_rdata == held, "R10 count held", count_rdata, held);
        check(irq == 1'b0, "R10 irq while off", irq, 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule